// File: doc/BRIEF.md
# Multilane Virtual-Channel Input Buffer

This block sits at the receiving end of one physical link. Its flit storage is split into several lanes, and each lane behaves as an independent circular queue with its own write and read pointer. A flit arrives with a lane number and two marker bits (packet head, packet tail) and is appended to that lane. Each lane shows its oldest flit to a switch-side consumer, which grants a lane a path and then pops flits from it, one lane per cycle at most.

Each lane runs a three-state machine. The states are `LANE_FREE` (code 0), `LANE_WAIT` (code 1) and `LANE_ACTIVE` (code 2). The transitions are:
- **claim**: `LANE_FREE` to `LANE_WAIT`, when a head flit is accepted.
- **grant**: `LANE_WAIT` to `LANE_ACTIVE`, when the downstream grant names the lane.
- **release**: `LANE_ACTIVE` to `LANE_FREE`, when a tail flit leaves and the lane is then empty.
- **requeue**: `LANE_ACTIVE` to `LANE_WAIT`, when a tail flit leaves and flits of a later packet remain.

Each effective pop sends one credit upstream, tagged with the lane number, so the sender knows which lane gained a free slot. A write to a full lane is dropped and sets a sticky error flag.

Top module: `vc_input_buffer`

## Requirements
- R1: After reset, every lane is `LANE_FREE` with occupancy 0 and no valid head, `credit_valid` is 0 and `overflow_err` is 0.
- R2: The flits of each lane leave in the order they were written, with no effect on any other lane. A lane's head (data, head bit, tail bit) and `head_valid` reflect the oldest stored flit after the clock edge that stores it.
- R3: Each lane holds `LANE_DEPTH` (default 4) flits. A write to a lane that is full at that edge is dropped, leaves the lane's contents and occupancy unchanged, and sets `overflow_err`. The flag then stays at 1 until reset.
- R4: `lane_state` carries 2 bits per lane, with lane i in bits [2i+1:2i] (0 = free, 1 = waiting, 2 = active). An accepted head flit moves a `LANE_FREE` lane to `LANE_WAIT`.
- R5: A grant naming a `LANE_WAIT` lane moves it to `LANE_ACTIVE`. A grant naming a lane in any other state has no effect.
- R6: A dequeue request takes effect only if the named lane is `LANE_ACTIVE` and non-empty. Any other request pops nothing and returns no credit.
- R7: An effective pop of lane L makes `credit_valid` 1 with `credit_lane` = L at the edge that performs the pop, for exactly one cycle. No credit is returned in a cycle without a pop.
- R8: When a tail flit is popped, the lane returns to `LANE_FREE` if it is empty afterwards, and to `LANE_WAIT` otherwise. Popping a non-tail flit keeps the lane `LANE_ACTIVE`.
- R9: If a lane that is not full is written and popped in the same cycle, both actions take place and its occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_lane | input | LW | Target lane of the incoming flit |
| in_head | input | 1 | Incoming flit starts a packet |
| in_tail | input | 1 | Incoming flit ends a packet |
| in_data | input | FLIT_W | Incoming flit payload |
| grant_valid | input | 1 | Downstream grants a path to one lane |
| grant_lane | input | LW | Lane that receives the grant |
| deq_valid | input | 1 | Downstream pops one flit |
| deq_lane | input | LW | Lane to pop |
| head_valid | output | NUM_LANES | Lane holds at least one flit |
| head_is_head | output | NUM_LANES | Head bit of each lane's oldest flit |
| head_is_tail | output | NUM_LANES | Tail bit of each lane's oldest flit |
| head_data | output | NUM_LANES*FLIT_W | Payload of each lane's oldest flit, lane i in slice i |
| lane_state | output | 2*NUM_LANES | Per-lane state code |
| lane_count | output | NUM_LANES*CW | Per-lane occupancy |
| credit_valid | output | 1 | A slot was freed in the lane given by credit_lane |
| credit_lane | output | LW | Lane of the returned credit |
| overflow_err | output | 1 | Sticky flag for a dropped write to a full lane |

## Verification
Every result here is registered. States, occupancies, heads, credits and the overflow flag all change at the single rising edge that samples the stimulus, and the credit stays for that one cycle only. The bench drives inputs at the falling edge and advances its own lane model at the next rising edge. It then compares every output at the following falling edge, which is exactly one cycle after the stimulus, so a credit that is late or held over fails the comparison. The directed steps place literal checks on the same sampling point.

// File: rtl/vcib_pkg.sv
package vcib_pkg;
    typedef enum logic [1:0] {
        LANE_FREE   = 2'd0,
        LANE_WAIT   = 2'd1,
        LANE_ACTIVE = 2'd2
    } lane_state_e;
endpackage

// File: rtl/vcib_lane_fifo.sv
module vcib_lane_fifo #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [WORD_W-1:0]         wr_word,
    input  logic                      rd_en,
    output logic [WORD_W-1:0]         front,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                      full,
    output logic                      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        front = mem[rd_ptr];
        count = cnt_q;
        full  = (cnt_q == CW'(DEPTH));
        empty = (cnt_q == '0);
    end

    // R3: the lane controller never pushes into a full queue
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R6: never pop an empty queue
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
    // R9: write plus pop in one cycle keeps occupancy
    p_keep_occupancy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> $stable(count));
    // R2: a lone write grows occupancy by one
    p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/vcib_lane_fsm.sv
module vcib_lane_fsm
    import vcib_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        head_accepted,
    input  logic        grant,
    input  logic        tail_popped,
    input  logic        left_nonempty,
    output lane_state_e state
);
    lane_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_FREE:   if (head_accepted) state_d = LANE_WAIT;
            LANE_WAIT:   if (grant)         state_d = LANE_ACTIVE;
            LANE_ACTIVE: if (tail_popped)   state_d = left_nonempty ? LANE_WAIT : LANE_FREE;
            default:                        state_d = LANE_FREE;
        endcase
    end

    assign state = state_q;

    // R4: claim transition
    p_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_FREE && head_accepted) |=> state_q == LANE_WAIT);
    // R5: grant to an active lane without tail pop changes nothing
    p_grant_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_ACTIVE && grant && !tail_popped) |=> state_q == LANE_ACTIVE);
    // R8: tail departure leaves active
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LANE_ACTIVE && tail_popped) |=> state_q != LANE_ACTIVE);
endmodule

// File: rtl/vcib_credit_ret.sv
module vcib_credit_ret #(
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_valid,
    input  logic [LW-1:0] pop_lane,
    output logic          credit_valid,
    output logic [LW-1:0] credit_lane
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit_valid <= 1'b0;
            credit_lane  <= '0;
        end else begin
            credit_valid <= pop_valid;
            if (pop_valid) credit_lane <= pop_lane;
        end
    end

    // R7: one tagged credit per pop, none otherwise
    p_credit_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |=> (credit_valid && credit_lane == $past(pop_lane)));
    p_credit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |=> !credit_valid);
endmodule

// File: rtl/vc_input_buffer.sv
module vc_input_buffer
    import vcib_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int LANE_DEPTH = 4,
    parameter int FLIT_W     = 16,
    parameter int LW         = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    parameter int CW         = $clog2(LANE_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [LW-1:0]               in_lane,
    input  logic                        in_head,
    input  logic                        in_tail,
    input  logic [FLIT_W-1:0]           in_data,
    input  logic                        grant_valid,
    input  logic [LW-1:0]               grant_lane,
    input  logic                        deq_valid,
    input  logic [LW-1:0]               deq_lane,
    output logic [NUM_LANES-1:0]        head_valid,
    output logic [NUM_LANES-1:0]        head_is_head,
    output logic [NUM_LANES-1:0]        head_is_tail,
    output logic [NUM_LANES*FLIT_W-1:0] head_data,
    output logic [2*NUM_LANES-1:0]      lane_state,
    output logic [NUM_LANES*CW-1:0]     lane_count,
    output logic                        credit_valid,
    output logic [LW-1:0]               credit_lane,
    output logic                        overflow_err
);
    localparam int WORD_W = FLIT_W + 2;

    logic [NUM_LANES-1:0] pop_en, drop_hit;
    logic                 ovf_q;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic              sel_wr, acc_wr, sel_deq, lane_full, lane_empty;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] front;
        lane_state_e       st;

        assign sel_wr     = in_valid && (in_lane == LW'(i));
        assign acc_wr     = sel_wr && !lane_full;
        assign drop_hit[i] = sel_wr && lane_full;
        assign sel_deq    = deq_valid && (deq_lane == LW'(i));
        assign pop_en[i]  = sel_deq && (st == LANE_ACTIVE) && !lane_empty;

        vcib_lane_fifo #(.DEPTH(LANE_DEPTH), .WORD_W(WORD_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (acc_wr),
            .wr_word ({in_head, in_tail, in_data}),
            .rd_en   (pop_en[i]),
            .front   (front),
            .count   (cnt),
            .full    (lane_full),
            .empty   (lane_empty)
        );

        vcib_lane_fsm u_fsm (
            .clk           (clk),
            .rst_n         (rst_n),
            .head_accepted (acc_wr && in_head),
            .grant         (grant_valid && (grant_lane == LW'(i))),
            .tail_popped   (pop_en[i] && front[FLIT_W]),
            .left_nonempty ((cnt > CW'(1)) || acc_wr),
            .state         (st)
        );

        assign head_valid[i]                   = !lane_empty;
        assign head_is_head[i]                 = front[FLIT_W+1];
        assign head_is_tail[i]                 = front[FLIT_W];
        assign head_data[i*FLIT_W +: FLIT_W]   = front[FLIT_W-1:0];
        assign lane_state[2*i +: 2]            = st;
        assign lane_count[i*CW +: CW]          = cnt;

        // R6: pops happen only on an active lane
        p_pop_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pop_en[i] |-> st == LANE_ACTIVE);
    end

    vcib_credit_ret #(.LW(LW)) u_credit (
        .clk          (clk),
        .rst_n        (rst_n),
        .pop_valid    (|pop_en),
        .pop_lane     (deq_lane),
        .credit_valid (credit_valid),
        .credit_lane  (credit_lane)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (|drop_hit) ovf_q <= 1'b1;
    end
    assign overflow_err = ovf_q;

    // R3: overflow flag is sticky
    p_sticky_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R3: a dropped write raises the flag
    p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|drop_hit) |=> ovf_q);
    // R7: a single dequeue port pops at most one lane
    p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_en));
endmodule

// File: tb/tb_vc_input_buffer.sv
`timescale 1ns/1ps
module tb_vc_input_buffer;
    localparam int NL = 4, DEP = 4, FW = 16, LW = 2, CW = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic in_valid, in_head, in_tail, grant_valid, deq_valid;
    logic [LW-1:0] in_lane, grant_lane, deq_lane;
    logic [FW-1:0] in_data;
    logic [NL-1:0] head_valid, head_is_head, head_is_tail;
    logic [NL*FW-1:0] head_data;
    logic [2*NL-1:0] lane_state;
    logic [NL*CW-1:0] lane_count;
    logic credit_valid, overflow_err;
    logic [LW-1:0] credit_lane;

    vc_input_buffer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lane(in_lane),
        .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
        .grant_valid(grant_valid), .grant_lane(grant_lane),
        .deq_valid(deq_valid), .deq_lane(deq_lane),
        .head_valid(head_valid), .head_is_head(head_is_head),
        .head_is_tail(head_is_tail), .head_data(head_data),
        .lane_state(lane_state), .lane_count(lane_count),
        .credit_valid(credit_valid), .credit_lane(credit_lane),
        .overflow_err(overflow_err)
    );

    // reference model
    logic [FW+1:0] mq [NL][DEP];
    int mcnt [NL];
    int mst  [NL];
    bit m_cv, m_ovf;
    int m_cl;
    int checks = 0, errors = 0;

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NL; i++) begin
            mcnt[i] = 0; mst[i] = 0;
        end
        m_cv = 0; m_cl = 0; m_ovf = 0;
    endtask

    task automatic model_step();
        bit any_pop = 0;
        for (int i = 0; i < NL; i++) begin
            bit wr   = in_valid && (int'(in_lane) == i);
            bit acc  = wr && (mcnt[i] < DEP);
            bit pop  = deq_valid && (int'(deq_lane) == i) && mst[i] == 2 && mcnt[i] > 0;
            bit gnt  = grant_valid && (int'(grant_lane) == i);
            bit ptail = 0;
            if (wr && !acc) m_ovf = 1;
            if (pop) begin
                ptail = mq[i][0][FW];
                for (int k = 0; k < DEP - 1; k++) mq[i][k] = mq[i][k+1];
                mcnt[i]--;
                any_pop = 1;
            end
            if (acc) begin
                mq[i][mcnt[i]] = {in_head, in_tail, in_data};
                mcnt[i]++;
            end
            case (mst[i])
                0: if (acc && in_head) mst[i] = 1;
                1: if (gnt) mst[i] = 2;
                default: if (pop && ptail) mst[i] = (mcnt[i] > 0) ? 1 : 0;
            endcase
        end
        m_cv = any_pop;
        if (any_pop) m_cl = int'(deq_lane);
    endtask

    task automatic compare_all();
        for (int i = 0; i < NL; i++) begin
            chk("R4/R5/R8", $sformatf("lane%0d state", i), lane_state[2*i +: 2], mst[i]);
            chk("R3/R9", $sformatf("lane%0d count", i), lane_count[i*CW +: CW], mcnt[i]);
            chk("R2", $sformatf("lane%0d head_valid", i), head_valid[i], mcnt[i] > 0);
            if (mcnt[i] > 0)
                chk("R2", $sformatf("lane%0d head word", i),
                    {head_is_head[i], head_is_tail[i], head_data[i*FW +: FW]}, mq[i][0]);
        end
        chk("R7", "credit_valid", credit_valid, m_cv);
        if (m_cv) chk("R7", "credit_lane", credit_lane, m_cl);
        chk("R3", "overflow_err", overflow_err, m_ovf);
    endtask

    task automatic idle();
        in_valid = 0; in_head = 0; in_tail = 0; in_data = '0; in_lane = '0;
        grant_valid = 0; grant_lane = '0; deq_valid = 0; deq_lane = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic put(int lane, bit h, bit t, int d);
        in_valid = 1; in_lane = LW'(lane); in_head = h; in_tail = t; in_data = FW'(d);
    endtask

    bit done = 0;
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle();
        rst_n = 0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "lane_state", lane_state, 0);
        chk("R1", "lane_count", lane_count, 0);
        chk("R1", "head_valid", head_valid, 0);
        chk("R1", "credit_valid", credit_valid, 0);
        chk("R1", "overflow_err", overflow_err, 0);

        // R5: grant on a free lane is ignored
        grant_valid = 1; grant_lane = 2'd1; tick();
        chk("R5", "free lane ignores grant", lane_state[3:2], 0);

        // R4: head into lane 0 claims it
        put(0, 1, 0, 16'h1111); tick();
        chk("R4", "lane0 waiting", lane_state[1:0], 1);
        put(0, 0, 0, 16'h2222); tick();
        put(0, 0, 0, 16'h3333); tick();
        put(0, 0, 1, 16'h4444); tick();
        chk("R3", "lane0 full", lane_count[2:0], 4);
        // R3: write to full lane dropped
        put(0, 0, 0, 16'hDEAD); tick();
        chk("R3", "overflow set", overflow_err, 1);
        chk("R3", "head unchanged", head_data[15:0], 16'h1111);

        // R6: dequeue of a waiting lane is ignored
        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R6", "no pop on waiting lane", lane_count[2:0], 4);
        chk("R6", "no credit", credit_valid, 0);

        grant_valid = 1; grant_lane = 2'd0; tick();
        chk("R5", "lane0 active", lane_state[1:0], 2);

        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R7", "credit after pop", credit_valid, 1);
        chk("R7", "credit lane", credit_lane, 0);
        chk("R2", "next head", head_data[15:0], 16'h2222);
        tick();
        chk("R7", "credit lasts one cycle", credit_valid, 0);

        // R9: write and pop in the same cycle
        put(0, 1, 0, 16'h5555); deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R9", "occupancy kept", lane_count[2:0], 3);
        deq_valid = 1; deq_lane = 2'd0; tick();
        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R8", "tail leaves with data behind: waiting", lane_state[1:0], 1);
        grant_valid = 1; grant_lane = 2'd0; tick();
        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R8", "non-tail pop stays active", lane_state[1:0], 2);
        put(0, 0, 1, 16'h6666); tick();
        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R8", "tail leaves empty lane: free", lane_state[1:0], 0);
        chk("R6", "empty dequeue later", lane_count[2:0], 0);
        deq_valid = 1; deq_lane = 2'd0; tick();
        chk("R6", "pop on free empty lane gives no credit", credit_valid, 0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) < 6)
                put($urandom_range(0, NL - 1), $urandom_range(0, 3) == 0,
                    $urandom_range(0, 2) == 0, $urandom_range(0, 65535));
            if ($urandom_range(0, 9) < 3) begin
                grant_valid = 1; grant_lane = LW'($urandom_range(0, NL - 1));
            end
            if ($urandom_range(0, 9) < 5) begin
                deq_valid = 1; deq_lane = LW'($urandom_range(0, NL - 1));
            end
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule